// File: doc/BRIEF.md
# Q-Phase Interrupt Controller for a Small 8-bit Core

This block holds the interrupt logic of a small 8-bit core whose instruction cycle is four phase clocks long (Q1 to Q4). It watches three sources: an external pin with a selectable active edge, a one-clock overflow pulse from a timer, and a group of port pins in which each pin can be armed for change detection. Each source has a sticky flag and an enable bit. A global enable decides whether pending work turns into a vector request to a fixed address.

The block runs on the phase clock. The core drives the current phase, a write strobe for the control word, a write strobe for the change mask, per-flag clear strobes, a port-read strobe, a return-from-interrupt strobe and its sleep status. The pin and port inputs are asynchronous and pass through two synchronizer flops. The pending request is sampled once per instruction cycle, at Q1. After the request is accepted, the instruction in flight completes, a dummy cycle follows, and the vector fetch cycle is then flagged. While the core sleeps, a wake request is raised from the enables that were set before sleep began. The global enable plays no part in the wake request.

Top module: `uc_irq_ctrl`

## Requirements
- R1: After reset all flags are 0, the global enable is 0, wake and vector request are 0, and the edge select is rising.
- R2: The control word is written with `ctl_wr_i`, with bits [0] ext enable, [1] timer enable, [2] change enable, [3] global enable and [4] edge select (1 = rising, 0 = falling). A transition of the external pin against the selected polarity never sets flag bit 0.
- R3: The phase code is 0=Q1, 1=Q2, 2=Q3, 3=Q4. A valid pin edge, seen after two synchronizer stages, sets flag bit 0 only on a clock edge whose phase is Q4 or Q1. If the pin changes before edge E1, the edge is detected at E3 and held until the first edge from E3 onward whose phase is Q4 or Q1.
- R4: A timer overflow pulse sets flag bit 1 at the next clock edge, whatever the phase.
- R5: A change on a port pin whose mask bit is 1 sets flag bit 2 on the third edge after the change. A change on a pin whose mask bit is 0 leaves the flag at 0. Each port read latches the synchronized pins as the new reference.
- R6: A port read whose clock edge has phase Q2, and which falls on the edge where a change would set flag bit 2, suppresses that set and absorbs the change. A read in any other phase does not suppress it.
- R7: Flags fall only through `flag_clr_i` (one strobe bit per flag). A set and a clear of the same flag in the same cycle leave the flag at 1.
- R8: The request is the OR of flag AND enable. When the global enable is 1 and the core is awake at a Q1 edge Es where the request is seen, `vec_req_o` is high from Es+8 for exactly four clocks, and `vec_addr_o` is 0x0004.
- R9: Accepting the vector clears the global enable at Es. A `reti_i` strobe sets it again.
- R10: While asleep, `wake_o` is high when a flag is set whose enable was already 1 before sleep began. An enable written during sleep does not wake the core.
- R11: With the global enable at 0, no vector request is raised even though an enabled flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qph_i | input | 2 | Current Q phase (0=Q1 .. 3=Q4) |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous |
| tmr_ovf_i | input | 1 | Timer rollover pulse, one clock |
| port_pins_i | input | NPIN | Port pins, asynchronous |
| port_rd_i | input | 1 | Port read strobe |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 5 | Control word data |
| mask_wr_i | input | 1 | Change mask write strobe |
| mask_wdata_i | input | NPIN | Change mask data |
| flag_clr_i | input | 3 | Per-flag clear strobes |
| reti_i | input | 1 | Return-from-interrupt strobe |
| sleep_i | input | 1 | Core is in sleep |
| flag_o | output | 3 | Flags: [0] ext, [1] timer, [2] change |
| gie_o | output | 1 | Global enable |
| wake_o | output | 1 | Wake request |
| vec_req_o | output | 1 | Vector fetch cycle indicator |
| vec_addr_o | output | AW | Vector address |

## Verification
A new timer overflow and a software clear of the timer flag can fall on the same clock edge. The bench provokes this by driving both strobes for one cycle and then checks that the flag still reads 1. For contrast, it clears the flag with no overflow pending and expects 0. A second overlap, between a port read in Q2 and a pending port change, is swept over all four phase alignments. Only the alignment that lands the read on a Q2 edge must lose the change.

// File: rtl/uc_irq_pkg.sv
package uc_irq_pkg;
  localparam int NSRC    = 3;
  localparam int SRC_EXT = 0;
  localparam int SRC_TMR = 1;
  localparam int SRC_CHG = 2;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } qphase_e;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_FINISH = 2'd1,
    SEQ_DUMMY  = 2'd2,
    SEQ_FETCH  = 2'd3
  } seq_e;

  // Control word layout, MSB first
  typedef struct packed {
    logic edge_rise;
    logic gie;
    logic chg_en;
    logic tmr_en;
    logic ext_en;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/uc_irq_sync.sv
module uc_irq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/uc_irq_src.sv
module uc_irq_src
  import uc_irq_pkg::*;
#(
  parameter int NPIN = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  qphase_e         ph,
  input  logic            ext_s,
  input  logic [NPIN-1:0] pins_s,
  input  logic            tmr_ovf,
  input  logic            port_rd,
  input  logic            edge_rise,
  input  logic [NPIN-1:0] chg_mask,
  input  logic [NSRC-1:0] flag_clr,
  output logic [NSRC-1:0] flags
);
  logic            ext_prev_q, ext_prev_d;
  logic            ext_pend_q, ext_pend_d;
  logic [NPIN-1:0] port_last_q, port_last_d;
  logic [NSRC-1:0] flag_q, flag_d;

  logic            ext_edge, ext_hit, phase_open, ext_set;
  logic            chg_diff, rd_window, chg_set;
  logic [NSRC-1:0] set_vec;

  always_comb begin
    ext_edge   = edge_rise ? (ext_s & ~ext_prev_q) : (~ext_s & ext_prev_q);
    phase_open = (ph == PH_Q4) || (ph == PH_Q1);
    ext_hit    = ext_edge | ext_pend_q;
    ext_set    = ext_hit & phase_open;
    ext_pend_d = ext_hit & ~phase_open;
    ext_prev_d = ext_s;

    chg_diff    = |((pins_s ^ port_last_q) & chg_mask);
    rd_window   = port_rd & (ph == PH_Q2);
    chg_set     = chg_diff & ~rd_window;
    port_last_d = port_rd ? pins_s : port_last_q;

    set_vec          = '0;
    set_vec[SRC_EXT] = ext_set;
    set_vec[SRC_TMR] = tmr_ovf;
    set_vec[SRC_CHG] = chg_set;
    flag_d           = (flag_q & ~flag_clr) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev_q  <= 1'b0;
      ext_pend_q  <= 1'b0;
      port_last_q <= '0;
      flag_q      <= '0;
    end else begin
      ext_prev_q  <= ext_prev_d;
      ext_pend_q  <= ext_pend_d;
      port_last_q <= port_last_d;
      flag_q      <= flag_d;
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/uc_irq_seq.sv
module uc_irq_seq
  import uc_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  qphase_e ph,
  input  logic    irq_pend,
  input  logic    sleep,
  input  logic    reti,
  input  logic    gie_wr,
  input  logic    gie_wdata,
  output logic    gie,
  output logic    vec_req
);
  seq_e state_q, state_d;
  logic gie_q, gie_d;
  logic at_q1, take;

  always_comb begin
    at_q1   = (ph == PH_Q1);
    take    = (state_q == SEQ_IDLE) & at_q1 & gie_q & irq_pend & ~sleep;
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:   if (take)  state_d = SEQ_FINISH;
      SEQ_FINISH: if (at_q1) state_d = SEQ_DUMMY;
      SEQ_DUMMY:  if (at_q1) state_d = SEQ_FETCH;
      SEQ_FETCH:  if (at_q1) state_d = SEQ_IDLE;
      default:    state_d = SEQ_IDLE;
    endcase

    gie_d = gie_q;
    if (gie_wr) gie_d = gie_wdata;
    if (reti)   gie_d = 1'b1;
    if (take)   gie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      gie_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      gie_q   <= gie_d;
    end
  end

  assign gie     = gie_q;
  assign vec_req = (state_q == SEQ_FETCH);
endmodule

// File: rtl/uc_irq_ctrl.sv
module uc_irq_ctrl
  import uc_irq_pkg::*;
#(
  parameter int          NPIN     = 6,
  parameter int          AW       = 13,
  parameter logic [12:0] VEC_ADDR = 13'h0004,
  parameter int          SYNC_STG = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          qph_i,
  input  logic                ext_pin_i,
  input  logic                tmr_ovf_i,
  input  logic [NPIN-1:0]     port_pins_i,
  input  logic                port_rd_i,
  input  logic                ctl_wr_i,
  input  logic [CTL_W-1:0]    ctl_wdata_i,
  input  logic                mask_wr_i,
  input  logic [NPIN-1:0]     mask_wdata_i,
  input  logic [NSRC-1:0]     flag_clr_i,
  input  logic                reti_i,
  input  logic                sleep_i,
  output logic [NSRC-1:0]     flag_o,
  output logic                gie_o,
  output logic                wake_o,
  output logic                vec_req_o,
  output logic [AW-1:0]       vec_addr_o
);
  localparam int SW = NPIN + 1;

  qphase_e         ph;
  ctl_t            cw;
  logic [SW-1:0]   sync_in, sync_out;
  logic            ext_s;
  logic [NPIN-1:0] pins_s;

  logic [NSRC-1:0] en_q, en_d, snap_q, snap_d;
  logic            edge_q, edge_d;
  logic [NPIN-1:0] mask_q, mask_d;
  logic [NSRC-1:0] flags;
  logic            irq_pend;

  assign ph      = qphase_e'(qph_i);
  assign cw      = ctl_t'(ctl_wdata_i);
  assign sync_in = {port_pins_i, ext_pin_i};
  assign ext_s   = sync_out[0];
  assign pins_s  = sync_out[SW-1:1];

  uc_irq_sync #(.W(SW), .STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   (sync_in),
    .q   (sync_out)
  );

  always_comb begin
    en_d   = en_q;
    edge_d = edge_q;
    mask_d = mask_q;
    if (ctl_wr_i) begin
      en_d[SRC_EXT] = cw.ext_en;
      en_d[SRC_TMR] = cw.tmr_en;
      en_d[SRC_CHG] = cw.chg_en;
      edge_d        = cw.edge_rise;
    end
    if (mask_wr_i) mask_d = mask_wdata_i;
    snap_d = sleep_i ? snap_q : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      edge_q <= 1'b1;
      mask_q <= '0;
      snap_q <= '0;
    end else begin
      en_q   <= en_d;
      edge_q <= edge_d;
      mask_q <= mask_d;
      snap_q <= snap_d;
    end
  end

  uc_irq_src #(.NPIN(NPIN)) u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph        (ph),
    .ext_s     (ext_s),
    .pins_s    (pins_s),
    .tmr_ovf   (tmr_ovf_i),
    .port_rd   (port_rd_i),
    .edge_rise (edge_q),
    .chg_mask  (mask_q),
    .flag_clr  (flag_clr_i),
    .flags     (flags)
  );

  assign irq_pend = |(flags & en_q);

  uc_irq_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph        (ph),
    .irq_pend  (irq_pend),
    .sleep     (sleep_i),
    .reti      (reti_i),
    .gie_wr    (ctl_wr_i),
    .gie_wdata (cw.gie),
    .gie       (gie_o),
    .vec_req   (vec_req_o)
  );

  assign flag_o     = flags;
  assign wake_o     = sleep_i & (|(flags & snap_q));
  assign vec_addr_o = AW'(VEC_ADDR);
endmodule

// File: rtl/uc_irq_ctrl_chk.sv
module uc_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] qph_i,
  input logic       tmr_ovf_i,
  input logic [2:0] flag_clr_i,
  input logic [2:0] flag_o,
  input logic       gie_o,
  input logic       vec_req_o
);
  AST_EXT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o[0]) |-> ($past(qph_i) == 2'd3 || $past(qph_i) == 2'd0)); // R3

  AST_TMR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf_i |=> flag_o[1]); // R4

  for (genvar g = 0; g < 3; g++) begin : g_sticky
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o[g]) |-> $past(flag_clr_i[g])); // R7
  end

  AST_VEC_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_req_o) |-> ($past(qph_i) == 2'd0)); // R8

  AST_VEC_GIE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_o |-> !gie_o); // R9
endmodule

bind uc_irq_ctrl uc_irq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .qph_i      (qph_i),
  .tmr_ovf_i  (tmr_ovf_i),
  .flag_clr_i (flag_clr_i),
  .flag_o     (flag_o),
  .gie_o      (gie_o),
  .vec_req_o  (vec_req_o)
);

// File: tb/uc_irq_ctrl_tb.sv
module uc_irq_ctrl_tb;
  localparam int NPIN = 6;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      qph;
  logic            ext_pin, tmr_ovf, port_rd, ctl_wr, mask_wr, reti, sleep;
  logic [NPIN-1:0] pins, mask_wdata;
  logic [4:0]      ctl_wdata;
  logic [2:0]      flag_clr;
  logic [2:0]      flag_o;
  logic            gie_o, wake_o, vec_req_o;
  logic [12:0]     vec_addr_o;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  uc_irq_ctrl #(.NPIN(NPIN)) u_dut (
    .clk (clk), .rst_n (rst_n), .qph_i (qph), .ext_pin_i (ext_pin),
    .tmr_ovf_i (tmr_ovf), .port_pins_i (pins), .port_rd_i (port_rd),
    .ctl_wr_i (ctl_wr), .ctl_wdata_i (ctl_wdata), .mask_wr_i (mask_wr),
    .mask_wdata_i (mask_wdata), .flag_clr_i (flag_clr), .reti_i (reti),
    .sleep_i (sleep), .flag_o (flag_o), .gie_o (gie_o), .wake_o (wake_o),
    .vec_req_o (vec_req_o), .vec_addr_o (vec_addr_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    qph      = qph + 2'd1;
    tmr_ovf  = 1'b0;
    port_rd  = 1'b0;
    ctl_wr   = 1'b0;
    mask_wr  = 1'b0;
    flag_clr = 3'b000;
    reti     = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wait_ph(input int p);
    while (int'(qph) != p) tick();
  endtask

  task automatic write_ctl(input logic [4:0] w);
    ctl_wr = 1'b1; ctl_wdata = w; tick();
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; qph = 2'd0; ext_pin = 1'b0; tmr_ovf = 1'b0; port_rd = 1'b0;
    ctl_wr = 1'b0; mask_wr = 1'b0; reti = 1'b0; sleep = 1'b0; pins = '0;
    mask_wdata = '0; ctl_wdata = '0; flag_clr = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 flags", int'(flag_o), 0);
    chk("R1 gie", int'(gie_o), 0);
    chk("R1 wake", int'(wake_o), 0);
    chk("R1 vec", int'(vec_req_o), 0);
    rst_n = 1'b1;
    ticks(2);
    chk("R1 vec_addr", int'(vec_addr_o), 4);

    // R2 / R3: both polarities, all phase alignments
    for (int pol = 1; pol >= 0; pol--) begin
      write_ctl({pol[0], 4'b0000});
      if (pol == 0) begin
        ext_pin = 1'b1;            // rising move in falling mode
        ticks(5);
        chk("R2 rising ignored in falling mode", int'(flag_o[0]), 0);
      end
      for (int p0 = 0; p0 < 4; p0++) begin
        int k, ph;
        flag_clr = 3'b111; tick();
        wait_ph(p0);
        ext_pin = pol[0];
        ph = (p0 + 2) % 4;
        k = 3;
        while (!(ph == 3 || ph == 0)) begin k++; ph = (ph + 1) % 4; end
        for (int s = 1; s <= 6; s++) begin
          tick();
          chk("R3 ext flag timing", int'(flag_o[0]), (s >= k) ? 1 : 0);
        end
        flag_clr = 3'b001; tick();
        ext_pin = ~pol[0];
        ticks(5);
        chk("R2 opposite edge ignored", int'(flag_o[0]), 0);
      end
    end

    // R4 timer overflow at every phase; R7 clear and collision
    for (int p = 0; p < 4; p++) begin
      wait_ph(p);
      tmr_ovf = 1'b1; tick();
      chk("R4 timer flag", int'(flag_o[1]), 1);
      tmr_ovf = 1'b1; flag_clr = 3'b010; tick();
      chk("R7 set beats clear", int'(flag_o[1]), 1);
      ticks(2);
      chk("R7 flag sticky", int'(flag_o[1]), 1);
      flag_clr = 3'b010; tick();
      chk("R7 clear", int'(flag_o[1]), 0);
    end

    // R5 per-pin mask
    mask_wr = 1'b1; mask_wdata = 6'b000101; tick();
    for (int i = 0; i < NPIN; i++) begin
      pins[i] = ~pins[i];
      ticks(2);
      chk("R5 change latency", int'(flag_o[2]), 0);
      tick();
      chk("R5 change flag vs mask", int'(flag_o[2]), int'(mask_wdata[i]));
      wait_ph(0);
      port_rd = 1'b1; tick();
      flag_clr = 3'b100; tick();
      ticks(2);
      chk("R5 read absorbs change", int'(flag_o[2]), 0);
    end

    // R6 read in Q2 masks coinciding change
    for (int p0 = 0; p0 < 4; p0++) begin
      int exp6;
      wait_ph(p0);
      pins[0] = ~pins[0];
      ticks(2);
      port_rd = 1'b1; tick();
      exp6 = (((p0 + 2) % 4) != 1) ? 1 : 0;
      chk("R6 read window", int'(flag_o[2]), exp6);
      ticks(3);
      chk("R6 held", int'(flag_o[2]), exp6);
      flag_clr = 3'b100; tick();
      chk("R6 cleared", int'(flag_o[2]), 0);
    end

    // R8 / R9 vector sequence per phase of the triggering pulse
    for (int p = 0; p < 4; p++) begin
      int j;
      write_ctl(5'b01010);
      chk("R9 gie written", int'(gie_o), 1);
      wait_ph(p);
      tmr_ovf = 1'b1;
      j = 2;
      while (((p + j - 1) % 4) != 0) j++;
      for (int s = 1; s <= j + 13; s++) begin
        tick();
        chk("R8 vec_req window", int'(vec_req_o),
            (s >= j + 8 && s <= j + 11) ? 1 : 0);
        if (s == j) chk("R9 gie cleared on take", int'(gie_o), 0);
      end
      flag_clr = 3'b010; tick();
      reti = 1'b1; tick();
      chk("R9 reti sets gie", int'(gie_o), 1);
      write_ctl(5'b00000);
    end

    // R11 global enable off
    write_ctl(5'b00010);
    tmr_ovf = 1'b1; tick();
    for (int s = 0; s < 16; s++) begin
      tick();
      chk("R11 no vector without gie", int'(vec_req_o), 0);
    end
    flag_clr = 3'b010; tick();

    // R10 wake from sleep
    sleep = 1'b1; tick();
    tmr_ovf = 1'b1; tick();
    chk("R10 wake with prior enable", int'(wake_o), 1);
    chk("R10 no vector while asleep", int'(vec_req_o), 0);
    flag_clr = 3'b010; tick();
    chk("R10 wake drops", int'(wake_o), 0);
    sleep = 1'b0; tick();
    write_ctl(5'b00000);
    tick();
    sleep = 1'b1; tick();
    write_ctl(5'b00010);
    tmr_ovf = 1'b1; tick();
    ticks(2);
    chk("R10 enable during sleep no wake", int'(wake_o), 0);
    flag_clr = 3'b010; sleep = 1'b0; tick();

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule